// File: doc/BRIEF.md
# Program Memory Byte Fetch Unit

This unit reads one byte out of a program memory whose storage is organised as 16-bit words. A 16-bit byte pointer supplies the address. The unit splits the pointer into a word index and a byte-lane select, reads the word from an external synchronous ROM, and returns the selected byte together with a destination register index and the pointer value that the core writes back.

A fetch starts with a single-cycle strobe that carries a form code, a destination index and the current pointer. Exactly three cycles later the result appears, together with a one-cycle done pulse. The form code decides two things: whether the destination is fixed at register 0 or taken from the request, and whether the pointer comes back incremented so that successive fetches walk through a table byte by byte. The unit changes no status flags and does no instruction decoding.

Top module: `pm_byte_fetch`

## Requirements
- R1: One cycle after an accepted start, rom_en_o is high for exactly that cycle and rom_addr_o equals the request pointer shifted right by one bit.
- R2: An even pointer returns bits 7:0 of the addressed word and an odd pointer returns bits 15:8. For example, the word 16'h5876 yields 8'h76 at pointer 0 and 8'h58 at pointer 1.
- R3: Form code 2'b00 (implied) reports destination 0 whatever dest_i holds, and returns the pointer unchanged.
- R4: Form code 2'b01 (explicit) reports dest_i as the destination and returns the pointer unchanged.
- R5: Form code 2'b10 (post-increment) reports dest_i as the destination and returns the pointer plus one.
- R6: A post-increment from 16'hFFFF returns 16'h0000.
- R7: done_o is high only in the third cycle after the start edge, and only for one cycle; data_o, dest_o and ptr_o are valid in that cycle.
- R8: A start that arrives while a fetch is in progress (including its done cycle) is ignored: it causes no ROM read, no extra done pulse and no change to the results.
- R9: After reset, done_o, rom_en_o, data_o, dest_o and ptr_o are all zero.
- R10: Form code 2'b11 behaves exactly like the explicit form.
- R11: data_o, dest_o and ptr_o hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fetch request strobe |
| form_i | input | 2 | Form code: 00 implied r0, 01 explicit, 10 explicit with post-increment, 11 as 01 |
| dest_i | input | 5 | Requested destination register index |
| ptr_i | input | 16 | Byte pointer at request time |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | 15 | ROM word address |
| rom_rdata_i | input | 16 | ROM word, valid the cycle after rom_en_o |
| data_o | output | 8 | Fetched byte |
| dest_o | output | 5 | Resolved destination register index |
| ptr_o | output | 16 | Pointer to write back |
| done_o | output | 1 | Result valid strobe |

## Verification
The sweeps target the lane choice at every low-bit parity. A unit that ignored bit 0, or that fed bit 0 into the word address, would return the same byte twice or bytes from the wrong word. Pointers near the top of the address space check the wrap: a unit with a carry-out bug would return a nonzero pointer after 16'hFFFF. Some fetches hold a second request active throughout the busy window, so a unit that re-armed early would show a second ROM read or overwritten results. A chained walk that feeds ptr_o back in checks that consecutive bytes come out in ascending order.

// File: rtl/pm_fetch_pkg.sv
package pm_fetch_pkg;
  typedef enum logic [1:0] {
    FORM_R0      = 2'd0,
    FORM_REG     = 2'd1,
    FORM_REG_INC = 2'd2,
    FORM_RSVD    = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } state_e;
endpackage

// File: rtl/pm_fetch_ctrl.sv
module pm_fetch_ctrl
  import pm_fetch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic rom_en_o,
  output logic capture_o,
  output logic done_o
);
  state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_LATCH;
      ST_LATCH: state_d = ST_READ;
      ST_READ:  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign rom_en_o  = (state_q == ST_LATCH);
  assign capture_o = (state_q == ST_READ);
  assign done_o    = (state_q == ST_DONE);

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_LATCH)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
endmodule

// File: rtl/pm_addr_split.sv
module pm_addr_split
  import pm_fetch_pkg::*;
#(
  parameter int ZW = 16,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [1:0]    form_i,
  input  logic [RW-1:0] dest_i,
  input  logic [ZW-1:0] ptr_i,
  output logic [ZW-2:0] word_o,
  output logic          lane_o,
  output logic [ZW-1:0] ptr_o,
  output logic          inc_o,
  output logic [RW-1:0] dest_o
);
  form_e          form;
  logic [RW-1:0]  dest_res;

  assign form     = form_e'(form_i);
  // implied form forces register 0
  assign dest_res = (form == FORM_R0) ? '0 : dest_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      lane_o <= 1'b0;
      ptr_o  <= '0;
      inc_o  <= 1'b0;
      dest_o <= '0;
    end else if (accept_i) begin
      word_o <= ptr_i[ZW-1:1];
      lane_o <= ptr_i[0];
      ptr_o  <= ptr_i;
      inc_o  <= (form == FORM_REG_INC);
      dest_o <= dest_res;
    end
  end
endmodule

// File: rtl/pm_byte_pick.sv
module pm_byte_pick #(
  parameter int ZW = 16,
  parameter int BW = 8,
  parameter int RW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            lane_i,
  input  logic [2*BW-1:0] rdata_i,
  input  logic [ZW-1:0]   ptr_i,
  input  logic            inc_i,
  input  logic [RW-1:0]   dest_i,
  output logic [BW-1:0]   data_o,
  output logic [ZW-1:0]   ptr_o,
  output logic [RW-1:0]   dest_o
);
  logic [BW-1:0] lane_byte;
  logic [ZW-1:0] ptr_next;

  assign lane_byte = lane_i ? rdata_i[2*BW-1:BW] : rdata_i[BW-1:0];
  // natural wrap at the top of the pointer range
  assign ptr_next  = inc_i ? ptr_i + ZW'(1) : ptr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      ptr_o  <= '0;
      dest_o <= '0;
    end else if (capture_i) begin
      data_o <= lane_byte;
      ptr_o  <= ptr_next;
      dest_o <= dest_i;
    end
  end
endmodule

// File: rtl/pm_byte_fetch.sv
module pm_byte_fetch
  import pm_fetch_pkg::*;
#(
  parameter int ZW = 16,
  parameter int BW = 8,
  parameter int RW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      form_i,
  input  logic [RW-1:0]   dest_i,
  input  logic [ZW-1:0]   ptr_i,
  output logic            rom_en_o,
  output logic [ZW-2:0]   rom_addr_o,
  input  logic [2*BW-1:0] rom_rdata_i,
  output logic [BW-1:0]   data_o,
  output logic [RW-1:0]   dest_o,
  output logic [ZW-1:0]   ptr_o,
  output logic            done_o
);
  typedef logic [ZW-1:0] ptr_t;

  logic          accept, capture, lane_q, inc_q;
  logic [ZW-1:0] ptr_q;
  logic [RW-1:0] dest_q;

  pm_fetch_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .accept_o  (accept),
    .rom_en_o  (rom_en_o),
    .capture_o (capture),
    .done_o    (done_o)
  );

  pm_addr_split #(.ZW(ZW), .RW(RW)) i_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .form_i   (form_i),
    .dest_i   (dest_i),
    .ptr_i    (ptr_i),
    .word_o   (rom_addr_o),
    .lane_o   (lane_q),
    .ptr_o    (ptr_q),
    .inc_o    (inc_q),
    .dest_o   (dest_q)
  );

  pm_byte_pick #(.ZW(ZW), .BW(BW), .RW(RW)) i_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .lane_i    (lane_q),
    .rdata_i   (rom_rdata_i),
    .ptr_i     (ptr_q),
    .inc_i     (inc_q),
    .dest_i    (dest_q),
    .data_o    (data_o),
    .ptr_o     (ptr_o),
    .dest_o    (dest_o)
  );

  AST_ROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> (rom_addr_o == $past(ptr_i[ZW-1:1]))); // R1
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3)); // R7
  AST_PTR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && form_e'($past(form_i, 3)) == FORM_REG_INC)
      |-> (ptr_o == ptr_t'($past(ptr_i, 3) + ptr_t'(1)))); // R5
  AST_PTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && form_e'($past(form_i, 3)) != FORM_REG_INC)
      |-> (ptr_o == $past(ptr_i, 3))); // R4
  AST_IMPLIED_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && form_e'($past(form_i, 3)) == FORM_R0) |-> (dest_o == '0)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(capture)) |-> $stable(data_o)); // R11
endmodule

// File: tb/pm_word_rom_model.sv
module pm_word_rom_model (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [14:0] addr_i,
  output logic [15:0] rdata_o
);
  logic [7:0] lo_b, hi_b;
  assign lo_b = addr_i[7:0] + {1'b0, addr_i[14:8]} + 8'h11;
  assign hi_b = addr_i[7:0] ^ {1'b0, addr_i[14:8]} ^ 8'h5A;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_o <= '0;
    else if (en_i && addr_i == 0) rdata_o <= 16'h5876;
    else if (en_i)               rdata_o <= {hi_b, lo_b};
  end
endmodule

// File: tb/test_pm_byte_fetch.sv
`timescale 1ns/1ps
module test_pm_byte_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  form = 2'd0;
  logic [4:0]  dest = 5'd0;
  logic [15:0] ptr = 16'd0;
  logic        rom_en, done;
  logic [14:0] rom_addr;
  logic [15:0] rom_rdata, ptr_out;
  logic [7:0]  data;
  logic [4:0]  dest_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pm_byte_fetch i_pm_byte_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .form_i(form),
    .dest_i(dest), .ptr_i(ptr), .rom_en_o(rom_en), .rom_addr_o(rom_addr),
    .rom_rdata_i(rom_rdata), .data_o(data), .dest_o(dest_out),
    .ptr_o(ptr_out), .done_o(done)
  );

  pm_word_rom_model i_rom (
    .clk_i(clk), .rst_ni(rst_n), .en_i(rom_en), .addr_i(rom_addr),
    .rdata_o(rom_rdata)
  );

  function automatic logic [15:0] exp_word(input logic [14:0] a);
    logic [7:0] lo, hi;
    if (a == 15'd0) return 16'h5876;
    lo = 8'(a[7:0] + a[14:8] + 8'h11);
    hi = a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic run_fetch(input logic [1:0] f, input logic [4:0] d,
                           input logic [15:0] p, input bit disturb,
                           output logic [15:0] p_ret);
    logic [15:0] w, e_ptr;
    logic [7:0]  e_byte;
    logic [4:0]  e_dest;
    string       dreq, preq;
    w      = exp_word(p[15:1]);
    e_byte = p[0] ? w[15:8] : w[7:0];
    e_dest = (f == 2'd0) ? 5'd0 : d;
    e_ptr  = (f == 2'd2) ? 16'(p + 16'd1) : p;
    dreq   = (f == 2'd0) ? "R3" : (f == 2'd3) ? "R10" : (f == 2'd2) ? "R5" : "R4";
    preq   = (f == 2'd2 && p == 16'hFFFF) ? "R6" : dreq;

    @(negedge clk);
    start = 1'b1; form = f; dest = d; ptr = p;
    @(negedge clk);
    check(rom_en == 1'b1, "R1", "rom_en", int'(rom_en), 1);
    check(rom_addr == p[15:1], "R1", "rom_addr", int'(rom_addr), int'(p[15:1]));
    check(done == 1'b0, "R7", "done early", int'(done), 0);
    if (disturb) begin
      form = ~f; dest = ~d; ptr = ~p;   // R8 stray request held through the busy window
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    check(done == 1'b0 && rom_en == 1'b0, "R7", "done/en mid", int'({done, rom_en}), 0);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R7", "done", int'(done), 1);
    check(data == e_byte, "R2", "data", int'(data), int'(e_byte));
    check(dest_out == e_dest, dreq, "dest", int'(dest_out), int'(e_dest));
    check(ptr_out == e_ptr, preq, "ptr", int'(ptr_out), int'(e_ptr));
    @(negedge clk);
    check(done == 1'b0, "R7", "done pulse width", int'(done), 0);
    check(rom_en == 1'b0, "R8", "stray read", int'(rom_en), 0);
    check(data == e_byte && ptr_out == e_ptr && dest_out == e_dest, "R11",
          "hold", int'(data), int'(e_byte));
    p_ret = ptr_out;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] pr;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(done == 0 && rom_en == 0, "R9", "ctrl reset", int'({done, rom_en}), 0);
    check(data == 0 && dest_out == 0 && ptr_out == 0, "R9", "data reset", int'(data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && data == 0 && ptr_out == 0, "R9", "after release", int'(ptr_out), 0);

    // R2 worked example: word 0x5876 walked by post-increment
    run_fetch(2'd2, 5'd16, 16'h0000, 1'b0, pr);
    check(data == 8'h76, "R2", "example low", int'(data), 8'h76);
    run_fetch(2'd1, 5'd17, pr, 1'b0, pr);
    check(data == 8'h58, "R2", "example high", int'(data), 8'h58);

    for (int i = 0; i < 256; i++)
      run_fetch(2'(i % 4), 5'((i * 7) % 32), 16'(i), (i % 5) == 0, pr);
    for (int i = 0; i < 256; i++)
      run_fetch(2'((i + 2) % 4), 5'((i * 11) % 32), 16'(16'hFF00 + i), (i % 3) == 0, pr);

    // R6 wrap then continue the walk
    run_fetch(2'd2, 5'd9, 16'hFFFF, 1'b1, pr);
    check(pr == 16'h0000, "R6", "wrap", int'(pr), 0);
    for (int i = 0; i < 6; i++) run_fetch(2'd2, 5'd3, pr, 1'b0, pr);
    check(pr == 16'd6, "R5", "walk end", int'(pr), 6);

    summary();
    $finish;
  end
endmodule